// File: doc/BRIEF.md
# Oscillator Period-Counting Temperature Sensor Front-End

This block turns a slow, temperature-dependent oscillator into a number. It counts reference-clock cycles while the oscillator completes a programmed number of its own periods. Because the oscillator runs faster when the die is hotter, a hotter die gives a smaller count. The latest count is held in a data register, and it is refreshed after every measurement for as long as measurement runs.

Software brings the block up in two steps. It first sets the enable bit and waits for the ready status bit, which rises after a fixed startup delay. It then sets the start bit, and measurement runs continuously from then on. To shut the block down, software clears start and then clears enable.

A window comparison runs on every completed count, using two 16-bit compare values. The low-compare flag marks a count at or below the low value, which means the die is getting hotter. The high-compare flag marks a count at or above the high value. Each flag is sticky. Software clears a flag by writing a 1 to the matching bit of the clear register. The interrupt output is a level signal.

The register port is a plain single-cycle write strobe with a combinational read. It has no valid/ready handshake and applies no back-pressure: a write takes effect on the clock edge at which `reg_we` is high, and `reg_rdata` follows `reg_addr` within the same cycle.

Top module: `tsn_meter`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is 0.
- R2: Status bit 15 (ready) rises exactly STARTUP_CYC cycles after the clock edge that writes control bit 0 (enable) to 1. It falls on the first edge after enable has been cleared.
- R3: No measurement takes place unless enable (control bit 0), start (control bit 4) and ready are all set. While any one of them is clear, the data register (offset 0x1C) keeps its value.
- R4: While measuring, data bits 15:0 hold the number of reference cycles spanned by N oscillator periods, where N is control bits 19:16. A new result is produced after every N periods. Bits 31:16 read 0.
- R5: An N field of 0 is treated as one oscillator period.
- R6: The low flag (status bit 1) sets when a completed count is less than or equal to the low compare value (threshold register 0x14, bits 15:0). The equal case sets the flag.
- R7: The high flag (status bit 2) sets when a completed count is greater than or equal to the high compare value (threshold bits 31:16). The equal case sets the flag.
- R8: Writing a 1 to a bit of the clear register (0x28) clears the matching status flag. Bits written as 0 leave their flag unchanged. A flag that is set and cleared in the same cycle stays set.
- R9: `irq_o` is high exactly when some status flag is set and the same bit of the interrupt enable register (0x24, implemented bits 2:0 and 6:4) is set.
- R10: The cycle count saturates at 0xFFFF.
- R11: In the control register (0x00), bits 30:24, 20:16, 11:8, 4 and 0 are stored and read back. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all counting is done in cycles of this clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_i | input | 1 | Temperature-dependent oscillator, asynchronous to `clk` |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
Register writes land on the edge at which `reg_we` is high, and reads are combinational. The bench therefore drives and samples registers on falling edges, half a cycle away from any active edge.

Ready is checked at two points, counted from the write edge: one falling edge before STARTUP_CYC cycles have passed, where it must still be low, and the first falling edge after, where it must be high. The loss of ready is checked one edge after enable is cleared.

A measured count only appears after the synchronizer latency, an arming edge and N full oscillator periods. After each start the bench therefore waits (N+2)·P plus a margin before it reads the data, and before every restart it lets the oscillator settle on its new period. Flags are read only after measurement has been stopped, so no new result can land between the stimulus and the read.

// File: rtl/tsn_pkg.sv
package tsn_pkg;
  localparam int ADDR_W = 8;

  // register byte offsets
  localparam logic [ADDR_W-1:0] A_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] A_THRESH = 8'h14;
  localparam logic [ADDR_W-1:0] A_COUNT  = 8'h1C;
  localparam logic [ADDR_W-1:0] A_STAT   = 8'h20;
  localparam logic [ADDR_W-1:0] A_IEN    = 8'h24;
  localparam logic [ADDR_W-1:0] A_ICLR   = 8'h28;

  // control fields
  localparam int B_EN    = 0;
  localparam int B_START = 4;
  localparam int SMP_LSB = 16;
  localparam logic [31:0] CTRL_MASK = 32'h7F1F_0F11;

  // status / enable / clear shared layout
  localparam int B_LO  = 1;
  localparam int B_HI  = 2;
  localparam int B_RDY = 15;
  localparam logic [6:0] FLAG_MASK = 7'h77;

  localparam int THR_W = 16;
endpackage

// File: rtl/tsn_osc_edge.sv
module tsn_osc_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_i,
  output logic rise_o
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], osc_i};
  end

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/tsn_startup.sv
module tsn_startup #(
  parameter int DELAY = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic rdy_o
);
  localparam int CW = $clog2(DELAY + 1);
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      rdy_o <= 1'b0;
    end else if (!en_i) begin
      cnt   <= '0;
      rdy_o <= 1'b0;
    end else if (!rdy_o) begin
      if (cnt == LAST) rdy_o <= 1'b1;
      else             cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tsn_period_count.sv
module tsn_period_count #(
  parameter int CNT_W = 16,
  parameter int PER_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             rise_i,
  input  logic [PER_W-1:0] nper_i,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic             armed;
  logic [CNT_W-1:0] cyc;
  logic [PER_W-1:0] per;
  logic [PER_W-1:0] last;
  logic [CNT_W-1:0] cyc_nx;
  logic             wrap;

  // an N of zero is measured as one period
  assign last   = (nper_i == '0) ? '0 : nper_i - 1'b1;
  assign cyc_nx = (cyc == CMAX) ? cyc : cyc + 1'b1;
  assign wrap   = (per >= last);
  assign done_o = run_i & armed & rise_i & wrap;
  assign count_o = cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cyc   <= '0;
      per   <= '0;
    end else if (!run_i) begin
      armed <= 1'b0;
      cyc   <= '0;
      per   <= '0;
    end else if (!armed) begin
      if (rise_i) begin
        armed <= 1'b1;
        cyc   <= CNT_W'(1);
        per   <= '0;
      end
    end else if (rise_i) begin
      if (wrap) begin
        cyc <= CNT_W'(1);
        per <= '0;
      end else begin
        cyc <= cyc_nx;
        per <= per + 1'b1;
      end
    end else begin
      cyc <= cyc_nx;
    end
  end
endmodule

// File: rtl/tsn_meter.sv
module tsn_meter
  import tsn_pkg::*;
#(
  parameter int STARTUP_CYC = 40,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 16,
  parameter int PER_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_i,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_o
);
  logic [31:0]      ctrl_q;
  logic [31:0]      thr_q;
  logic [CNT_W-1:0] data_q;
  logic [6:0]       ien_q;
  logic             flag_lo, flag_hi;

  logic             en_w, run_w, rdy_w, rise_w, done_w;
  logic [CNT_W-1:0] count_w;
  logic             clr_lo_w, clr_hi_w, lo_hit, hi_hit;
  logic [31:0]      stat_w;

  assign en_w  = ctrl_q[B_EN];
  assign run_w = en_w & ctrl_q[B_START] & rdy_w;

  tsn_osc_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .osc_i(osc_i), .rise_o(rise_w)
  );

  tsn_startup #(.DELAY(STARTUP_CYC)) u_start (
    .clk(clk), .rst_n(rst_n), .en_i(en_w), .rdy_o(rdy_w)
  );

  tsn_period_count #(.CNT_W(CNT_W), .PER_W(PER_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(run_w), .rise_i(rise_w),
    .nper_i(ctrl_q[SMP_LSB +: PER_W]), .done_o(done_w), .count_o(count_w)
  );

  assign lo_hit   = done_w & ({{(32-CNT_W){1'b0}}, count_w} <= {16'b0, thr_q[THR_W-1:0]});
  assign hi_hit   = done_w & ({{(32-CNT_W){1'b0}}, count_w} >= {16'b0, thr_q[31:THR_W]});
  assign clr_lo_w = reg_we & (reg_addr == A_ICLR) & reg_wdata[B_LO];
  assign clr_hi_w = reg_we & (reg_addr == A_ICLR) & reg_wdata[B_HI];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      thr_q  <= '0;
      ien_q  <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_CTRL:   ctrl_q <= reg_wdata & CTRL_MASK;
        A_THRESH: thr_q  <= reg_wdata;
        A_IEN:    ien_q  <= reg_wdata[6:0] & FLAG_MASK;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (done_w) data_q <= count_w;
  end

  // a new event wins over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_lo <= 1'b0;
      flag_hi <= 1'b0;
    end else begin
      if (lo_hit)        flag_lo <= 1'b1;
      else if (clr_lo_w) flag_lo <= 1'b0;
      if (hi_hit)        flag_hi <= 1'b1;
      else if (clr_hi_w) flag_hi <= 1'b0;
    end
  end

  always_comb begin
    stat_w        = '0;
    stat_w[B_RDY] = rdy_w;
    stat_w[B_LO]  = flag_lo;
    stat_w[B_HI]  = flag_hi;
  end

  assign irq_o = |(stat_w[6:0] & ien_q);

  always_comb begin
    case (reg_addr)
      A_CTRL:   reg_rdata = ctrl_q;
      A_THRESH: reg_rdata = thr_q;
      A_COUNT:  reg_rdata = {{(32-CNT_W){1'b0}}, data_q};
      A_STAT:   reg_rdata = stat_w;
      A_IEN:    reg_rdata = {25'b0, ien_q};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tsn_meter_chk.sv
module tsn_meter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_i,
  input logic             rdy_i,
  input logic             run_i,
  input logic             done_i,
  input logic [CNT_W-1:0] data_i,
  input logic             flag_lo_i,
  input logic             flag_hi_i,
  input logic             clr_lo_i
);
  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !rdy_i);

  // R2
  ready_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_i) |-> en_i);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(data_i));

  // R6
  lo_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_lo_i) |-> $past(done_i));

  // R7
  hi_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_hi_i) |-> $past(done_i));

  // R8
  lo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_lo_i && !done_i) |=> !flag_lo_i);
endmodule

bind tsn_meter tsn_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_w), .rdy_i(rdy_w), .run_i(run_w),
  .done_i(done_w), .data_i(data_q), .flag_lo_i(flag_lo), .flag_hi_i(flag_hi),
  .clr_lo_i(clr_lo_w)
);

// File: tb/tsn_meter_bench.sv
module tsn_meter_bench;
  import tsn_pkg::*;

  localparam int SU = 40;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              osc = 1'b0;
  logic              we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              irq;

  int tests = 0;
  int fails = 0;
  int osc_per = 0;

  tsn_meter #(.STARTUP_CYC(SU)) u_tsn_meter (
    .clk(clk), .rst_n(rst_n), .osc_i(osc), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
  );

  always #5 clk = ~clk;

  // oscillator model: one full period per loop, period read at its start
  initial begin
    forever begin
      if (osc_per < 2) begin
        osc = 1'b0;
        @(negedge clk);
      end else begin
        int p;
        p = osc_per;
        osc = 1'b1;
        repeat (p / 2) @(negedge clk);
        osc = 1'b0;
        repeat (p - p / 2) @(negedge clk);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic [31:0] ctrl_val(input int n, input bit start);
    return 32'h1 | (32'(start) << B_START) | (32'(n & 15) << SMP_LSB);
  endfunction

  function automatic logic [31:0] exp_count(input int n, input int p);
    int v;
    v = ((n == 0) ? 1 : n) * p;
    return (v > 65535) ? 32'h0000_FFFF : 32'(v);
  endfunction

  // stop, retune the oscillator, let it settle, restart and wait for results
  task automatic measure(input int n, input int p);
    wr(A_CTRL, ctrl_val(n, 1'b0));
    osc_per = p;
    repeat (100) @(negedge clk);
    wr(A_CTRL, ctrl_val(n, 1'b1));
    repeat (((n == 0 ? 1 : n) + 2) * p + 20) @(negedge clk);
  endtask

  task automatic stop_meas();
    wr(A_CTRL, ctrl_val(2, 1'b0));
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] held;
    void'($urandom(32'd2718));

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(A_CTRL, v);   chk("R1 ctrl", v, 0);
    rd(A_THRESH, v); chk("R1 thresh", v, 0);
    rd(A_COUNT, v);  chk("R1 count", v, 0);
    rd(A_STAT, v);   chk("R1 status", v, 0);
    rd(A_IEN, v);    chk("R1 ien", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R11 control readback mask
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R11 ctrl mask", v, 32'h7F1F_0F11);
    wr(A_CTRL, 32'h0);
    repeat (3) @(negedge clk);

    // R2 startup delay
    osc_per = 10;
    wr(A_CTRL, ctrl_val(4, 1'b0));
    repeat (SU - 1) @(negedge clk);
    rd(A_STAT, v); chk("R2 not yet ready", {31'b0, v[B_RDY]}, 0);
    @(negedge clk);
    rd(A_STAT, v); chk("R2 ready after delay", {31'b0, v[B_RDY]}, 1);

    // R3 enabled but not started
    repeat (200) @(negedge clk);
    rd(A_COUNT, v); chk("R3 no start no data", v, 0);

    // R4 directed
    measure(4, 10);
    rd(A_COUNT, v); chk("R4 count N=4 P=10", v, exp_count(4, 10));

    // R4 random
    for (int i = 0; i < 5; i++) begin
      int n, p;
      n = $urandom_range(1, 15);
      p = $urandom_range(4, 40);
      measure(n, p);
      rd(A_COUNT, v); chk("R4 random count", v, exp_count(n, p));
    end

    // R5 N field zero
    measure(0, 23);
    rd(A_COUNT, v); chk("R5 N=0 one period", v, exp_count(0, 23));

    // R3 stopped: data holds under a new oscillator period
    stop_meas();
    rd(A_COUNT, held);
    osc_per = 13;
    repeat (300) @(negedge clk);
    rd(A_COUNT, v); chk("R3 stopped data holds", v, held);

    // R6 / R7 boundaries, count 40
    wr(A_ICLR, 32'h77);
    rd(A_STAT, v); chk("R8 clear all", {29'b0, v[2:0]}, 0);
    wr(A_THRESH, {16'hFFFF, 16'd40});
    measure(2, 20);
    stop_meas();
    rd(A_STAT, v); chk("R6 low equal sets", {31'b0, v[B_LO]}, 1);
    chk("R7 high not reached", {31'b0, v[B_HI]}, 0);

    wr(A_ICLR, 32'h77);
    wr(A_THRESH, {16'd41, 16'd39});
    measure(2, 20);
    stop_meas();
    rd(A_STAT, v); chk("R6 low 39 vs 40 clear", {31'b0, v[B_LO]}, 0);
    chk("R7 high 41 vs 40 clear", {31'b0, v[B_HI]}, 0);

    wr(A_ICLR, 32'h77);
    wr(A_THRESH, {16'd40, 16'd0});
    measure(2, 20);
    stop_meas();
    rd(A_STAT, v); chk("R7 high equal sets", {31'b0, v[B_HI]}, 1);

    for (int i = 0; i < 3; i++) begin
      int lo, hi;
      lo = $urandom_range(20, 60);
      hi = $urandom_range(20, 60);
      wr(A_ICLR, 32'h77);
      wr(A_THRESH, {16'(hi), 16'(lo)});
      measure(2, 20);
      stop_meas();
      rd(A_STAT, v);
      chk("R6 random low", {31'b0, v[B_LO]}, (40 <= lo) ? 1 : 0);
      chk("R7 random high", {31'b0, v[B_HI]}, (40 >= hi) ? 1 : 0);
    end

    // R8 selective clear
    wr(A_ICLR, 32'h77);
    wr(A_THRESH, {16'd0, 16'hFFFF});
    measure(2, 20);
    stop_meas();
    rd(A_STAT, v); chk("R8 both set", {29'b0, v[2:0]}, 32'h6);
    wr(A_ICLR, 32'h04);
    rd(A_STAT, v); chk("R8 clear high only", {29'b0, v[2:0]}, 32'h2);
    wr(A_ICLR, 32'h00);
    rd(A_STAT, v); chk("R8 zero write no effect", {29'b0, v[2:0]}, 32'h2);

    // R9 interrupt masking
    wr(A_IEN, 32'h0);
    chk("R9 masked no irq", {31'b0, irq}, 0);
    wr(A_IEN, 32'h02);
    chk("R9 low enabled irq", {31'b0, irq}, 1);
    wr(A_IEN, 32'h04);
    chk("R9 high enabled but clear", {31'b0, irq}, 0);
    wr(A_IEN, 32'hFF);
    rd(A_IEN, v); chk("R9 ien mask", v, 32'h77);
    wr(A_ICLR, 32'h02);
    chk("R9 cleared no irq", {31'b0, irq}, 0);

    // R10 saturation
    measure(15, 4400);
    rd(A_COUNT, v); chk("R10 saturated count", v, 32'h0000_FFFF);

    // R2 ready falls after disable
    wr(A_CTRL, 32'h0);
    @(negedge clk);
    rd(A_STAT, v); chk("R2 ready falls", {31'b0, v[B_RDY]}, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule